// File: doc/BRIEF.md
# Truncating Floating-Point Multiplier

This unit multiplies two normalized binary floating-point words and returns their packed product, together with flags that mark an exponent that left the representable range. A single parameter chooses the format: a 32-bit word (8-bit exponent, 23-bit fraction, bias 127) or a 64-bit word (11-bit exponent, 52-bit fraction, bias 1023).

The work is split over two register stages. The first stage splits the fields, spots a zero operand, forms the product sign and the unbiased exponent sum, and restores the hidden leading one of each significand. The second stage multiplies the significands, shifts the product right by one place when it reaches two, and drops every fraction bit below the kept width without rounding. It then decides between a normal result, a zero, an overflow and an underflow, and packs the word.

Denormal inputs, infinities and NaNs have no special meaning here. An exponent field of zero is read as the value zero, and an all-ones field is treated as an ordinary exponent. The unit accepts a new operand pair on every clock.

Top module: `fpmul_core`

## Requirements
- R1: The product of the operands sampled at one rising clock edge appears on the outputs after the second rising edge. While rst_n is low, result, overflow and underflow are all zero.
- R2: If either operand has an exponent field of zero, result is the sign from R3 followed by all-zero exponent and fraction bits, and both flags stay low.
- R3: The result sign bit (the word's most significant bit) is the XOR of the two operand sign bits in every case, including zero, overflow and underflow.
- R4: For nonzero operands the raw exponent is ea + eb - bias, where ea and eb are the biased exponent fields.
- R5: The significands 1.fa and 1.fb are multiplied. If the product is at least 2, it is shifted right by one and the exponent from R4 is raised by one. The fraction field is then the bits just below the leading one, with all lower bits discarded (truncation, no rounding). When the final exponent lies in 1 .. 2^E-2, it is packed unchanged into the field, where E is the exponent width.
- R6: When the final exponent is 2^E-1 or more, overflow is 1 and result is the sign followed by an all-ones exponent and an all-zero fraction.
- R7: When the final exponent is 0 or less, underflow is 1 and result is the sign followed by zeros.
- R8: overflow and underflow are never high together, and the zero rule of R2 takes precedence over both.
- R9: Parameter DOUBLE=0 gives a 32-bit word {sign, 8-bit exponent, 23-bit fraction} with bias 127. DOUBLE=1 gives a 64-bit word {sign, 11-bit exponent, 52-bit fraction} with bias 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W (32 or 64) | First packed operand |
| op_b | input | W (32 or 64) | Second packed operand |
| result | output | W (32 or 64) | Packed truncated product |
| overflow | output | 1 | Final exponent too large; result saturated to signed all-ones exponent |
| underflow | output | 1 | Final exponent too small; result forced to signed zero |

## Verification
The normalization shift and the range decision fall in the same cycle. A product of two or more adds one to the exponent just before it is compared with the limits. The bench provokes this with exponent pairs whose sum lands exactly on 2^E-2 or on 0, and pairs each with significands whose product is below two and at or above two. The expected outcome flips between a normal word and overflow, or between underflow and a normal word. The bench also aims a zero operand at exponent pairs that would otherwise overflow, which shows the zero rule winning. A behavioural model built on wide integer products judges every cycle, for both precisions side by side.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_ZERO   = 2'd1,
        CLS_OVER   = 2'd2,
        CLS_UNDER  = 2'd3
    } prod_class_e;

    function automatic int exp_bits(bit dbl);
        return dbl ? 11 : 8;
    endfunction

    function automatic int frac_bits(bit dbl);
        return dbl ? 52 : 23;
    endfunction

    function automatic int bias_of(bit dbl);
        return dbl ? 1023 : 127;
    endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int BIAS   = 127,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1,
    localparam int XE_W  = EXP_W + 2
) (
    input  logic [W-1:0]            op_a,
    input  logic [W-1:0]            op_b,
    output logic                    sign,
    output logic                    zero,
    output logic signed [XE_W-1:0]  exp_sum,
    output logic [SIG_W-1:0]        sig_a,
    output logic [SIG_W-1:0]        sig_b
);

    logic [W-1:0]      ops   [2];
    logic              s_fld [2];
    logic [EXP_W-1:0]  e_fld [2];
    logic [FRAC_W-1:0] f_fld [2];
    logic              z_fld [2];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < 2; i++) begin : g_field
        assign s_fld[i] = ops[i][W-1];
        assign e_fld[i] = ops[i][W-2:FRAC_W];
        assign f_fld[i] = ops[i][FRAC_W-1:0];
        assign z_fld[i] = (e_fld[i] == '0);
    end

    assign sign    = s_fld[0] ^ s_fld[1];
    assign zero    = z_fld[0] | z_fld[1];
    assign exp_sum = $signed({2'b00, e_fld[0]}) + $signed({2'b00, e_fld[1]})
                   - $signed(XE_W'(BIAS));
    assign sig_a   = {1'b1, f_fld[0]};
    assign sig_b   = {1'b1, f_fld[1]};

endmodule

// File: rtl/fpm_sig_mul.sv
module fpm_sig_mul #(
    parameter int N = 24,
    localparam int PW = 2 * N
) (
    input  logic [N-1:0]  a,
    input  logic [N-1:0]  b,
    output logic [PW-1:0] prod
);

    logic [PW-1:0] acc [N+1];

    assign acc[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_row
        logic [PW-1:0] row;
        assign row        = b[i] ? (PW'(a) << i) : '0;
        assign acc[i + 1] = acc[i] + row;
    end

    assign prod = acc[N];

endmodule

// File: rtl/fpm_norm_pack.sv
module fpm_norm_pack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1,
    localparam int PW    = 2 * SIG_W,
    localparam int XE_W  = EXP_W + 2
) (
    input  logic                   sign,
    input  logic                   zero,
    input  logic signed [XE_W-1:0] exp_sum,
    input  logic [PW-1:0]          prod,
    output logic [W-1:0]           word,
    output logic                   over,
    output logic                   under
);

    localparam logic signed [XE_W-1:0] EXP_TOP = XE_W'((1 << EXP_W) - 1);

    logic                   carry;
    logic [FRAC_W-1:0]      frac;
    logic signed [XE_W-1:0] exp_n;
    prod_class_e            cls;
    logic                   unused_low;

    assign unused_low = ^prod[FRAC_W-1:0];

    always_comb begin
        carry = prod[PW-1];
        frac  = carry ? prod[PW-2 -: FRAC_W] : prod[PW-3 -: FRAC_W];
        exp_n = exp_sum + $signed(XE_W'(carry));

        if (zero) begin
            cls = CLS_ZERO;
        end else if (exp_n >= EXP_TOP) begin
            cls = CLS_OVER;
        end else if (exp_n <= 0) begin
            cls = CLS_UNDER;
        end else begin
            cls = CLS_NORMAL;
        end

        case (cls)
            CLS_OVER:   word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            CLS_NORMAL: word = {sign, exp_n[EXP_W-1:0], frac};
            default:    word = {sign, {(W-1){1'b0}}};
        endcase

        over  = (cls == CLS_OVER);
        under = (cls == CLS_UNDER);
    end

endmodule

// File: rtl/fpmul_core.sv
module fpmul_core
    import fpm_pkg::*;
#(
    parameter bit DOUBLE = 1'b0,
    localparam int EXP_W  = exp_bits(DOUBLE),
    localparam int FRAC_W = frac_bits(DOUBLE),
    localparam int BIAS   = bias_of(DOUBLE),
    localparam int W      = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] result,
    output logic         overflow,
    output logic         underflow
);

    localparam int SIG_W = FRAC_W + 1;
    localparam int PW    = 2 * SIG_W;
    localparam int XE_W  = EXP_W + 2;

    typedef struct packed {
        logic                   sign;
        logic                   zero;
        logic signed [XE_W-1:0] exp_sum;
        logic [SIG_W-1:0]       sig_a;
        logic [SIG_W-1:0]       sig_b;
    } stage1_t;

    typedef struct packed {
        logic [W-1:0] word;
        logic         over;
        logic         under;
    } stage2_t;

    localparam stage1_t S1_RST = '{sign: 1'b0, zero: 1'b1, exp_sum: '0,
                                   sig_a: '0, sig_b: '0};

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    logic                   u_sign;
    logic                   u_zero;
    logic signed [XE_W-1:0] u_exp;
    logic [SIG_W-1:0]       u_sig_a;
    logic [SIG_W-1:0]       u_sig_b;
    logic [PW-1:0]          m_prod;
    logic [W-1:0]           n_word;
    logic                   n_over;
    logic                   n_under;

    fpm_unpack #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W),
        .BIAS   (BIAS)
    ) u_unpack (
        .op_a    (op_a),
        .op_b    (op_b),
        .sign    (u_sign),
        .zero    (u_zero),
        .exp_sum (u_exp),
        .sig_a   (u_sig_a),
        .sig_b   (u_sig_b)
    );

    fpm_sig_mul #(
        .N (SIG_W)
    ) u_sig_mul (
        .a    (s1_q.sig_a),
        .b    (s1_q.sig_b),
        .prod (m_prod)
    );

    fpm_norm_pack #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_norm_pack (
        .sign    (s1_q.sign),
        .zero    (s1_q.zero),
        .exp_sum (s1_q.exp_sum),
        .prod    (m_prod),
        .word    (n_word),
        .over    (n_over),
        .under   (n_under)
    );

    always_comb begin
        s1_d         = s1_q;
        s1_d.sign    = u_sign;
        s1_d.zero    = u_zero;
        s1_d.exp_sum = u_exp;
        s1_d.sig_a   = u_sig_a;
        s1_d.sig_b   = u_sig_b;

        s2_d         = s2_q;
        s2_d.word    = n_word;
        s2_d.over    = n_over;
        s2_d.under   = n_under;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= S1_RST;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign result    = s2_q.word;
    assign overflow  = s2_q.over;
    assign underflow = s2_q.under;

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic [EXP_W:0] hi_a,
    input logic [EXP_W:0] hi_b,
    input logic [W-1:0] result,
    input logic         overflow,
    input logic         underflow
);

    logic [1:0] fill_q;
    logic       window;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= 2'd0;
        end else if (fill_q != 2'd2) begin
            fill_q <= fill_q + 2'd1;
        end
    end

    assign window = (fill_q == 2'd2);

    p_zero_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (window && ($past(hi_a[EXP_W-1:0], 2) == '0 || $past(hi_b[EXP_W-1:0], 2) == '0))
        |-> (result[W-2:0] == '0 && !overflow && !underflow));

    p_sign_xor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        window |-> (result[W-1] == $past(hi_a[EXP_W] ^ hi_b[EXP_W], 2)));

    p_normal_exp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!overflow && !underflow && result[W-2:FRAC_W] != '0)
        |-> (result[W-2:FRAC_W] != '1));

    p_ovf_pack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (result[W-2:FRAC_W] == '1 && result[FRAC_W-1:0] == '0));

    p_unf_pack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (result[W-2:0] == '0));

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({overflow, underflow}));

endmodule

bind fpmul_core fpm_checker #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) u_fpm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_a      (op_a[W-1:FRAC_W]),
    .hi_b      (op_b[W-1:FRAC_W]),
    .result    (result),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/test_fpmul_core.sv
module test_fpmul_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_sp = '0, b_sp = '0, r_sp;
    logic [63:0] a_dp = '0, b_dp = '0, r_dp;
    logic        ov_sp, un_sp, ov_dp, un_dp;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [63:0] r;
        bit          ov;
        bit          un;
        string       tag;
    } exp_t;

    exp_t sp1, sp2, dp1, dp2;

    always #2 clk = ~clk;

    fpmul_core #(.DOUBLE(1'b0)) i_fpmul_core (
        .clk(clk), .rst_n(rst_n), .op_a(a_sp), .op_b(b_sp),
        .result(r_sp), .overflow(ov_sp), .underflow(un_sp));

    fpmul_core #(.DOUBLE(1'b1)) i_fpmul_core_dp (
        .clk(clk), .rst_n(rst_n), .op_a(a_dp), .op_b(b_dp),
        .result(r_dp), .overflow(ov_dp), .underflow(un_dp));

    // Behavioural reference: wide integer product, integer exponent arithmetic
    function automatic exp_t model(bit dp, logic [63:0] a, logic [63:0] b);
        exp_t             x;
        int               fw    = dp ? 52 : 23;
        int               ew    = dp ? 11 : 8;
        int               bias  = dp ? 1023 : 127;
        longint unsigned  fmask = (64'd1 << fw) - 1;
        int               emax  = (1 << ew) - 1;
        int               ea    = int'((a >> fw) & 64'(emax));
        int               eb    = int'((b >> fw) & 64'(emax));
        logic [63:0]      sgn   = 64'(a[fw + ew] ^ b[fw + ew]) << (fw + ew);
        logic [127:0]     p;
        longint unsigned  frac;
        int               e;
        p = 128'((64'd1 << fw) | (a & fmask)) * 128'((64'd1 << fw) | (b & fmask));
        e = ea + eb - bias;
        x.ov = 1'b0;
        x.un = 1'b0;
        if (ea == 0 || eb == 0) begin
            x.r   = sgn;
            x.tag = "R2 R3 R8";
        end else begin
            if (p[2 * fw + 1]) begin
                frac = 64'(p >> (fw + 1)) & fmask;
                e    = e + 1;
            end else begin
                frac = 64'(p >> fw) & fmask;
            end
            if (e >= emax) begin
                x.ov  = 1'b1;
                x.r   = sgn | (64'(emax) << fw);
                x.tag = "R6 R8";
            end else if (e <= 0) begin
                x.un  = 1'b1;
                x.r   = sgn;
                x.tag = "R7 R8";
            end else begin
                x.r   = sgn | (64'(e) << fw) | frac;
                x.tag = "R3 R4 R5";
            end
        end
        return x;
    endfunction

    task automatic compare(bit dp, exp_t e, logic [63:0] r, bit ov, bit un);
        n_vec++;
        if (r !== e.r || ov !== e.ov || un !== e.un) begin
            n_bad++;
            $display("FAIL R1 %s%s: got r=%h ov=%0b un=%0b, expected r=%h ov=%0b un=%0b",
                     e.tag, dp ? " R9" : "", r, ov, un, e.r, e.ov, e.un);
        end
    endtask

    function automatic logic [31:0] mk_sp(bit s, int e, int f);
        return {s, 8'(e), 23'(f)};
    endfunction

    function automatic logic [63:0] mk_dp(bit s, int e, longint f);
        return {s, 11'(e), 52'(f)};
    endfunction

    function automatic logic [63:0] rand_op(bit dp);
        int              ew    = dp ? 11 : 8;
        int              fw    = dp ? 52 : 23;
        int              bias  = dp ? 1023 : 127;
        int              emax  = (1 << ew) - 1;
        int              lo_c  = bias / 2 + 1;
        int              hi_c  = (emax - 1 + bias) / 2;
        int              pick  = $urandom_range(0, 9);
        int              e;
        longint unsigned f = {$urandom, $urandom};
        bit              s = 1'($urandom_range(0, 1));
        if (pick == 0)      e = 0;
        else if (pick <= 2) e = lo_c + $urandom_range(0, 6) - 3;
        else if (pick <= 4) e = hi_c + $urandom_range(0, 6) - 3;
        else                e = $urandom_range(1, emax - 1);
        f = f & ((64'd1 << fw) - 1);
        return (64'(s) << (fw + ew)) | (64'(e) << fw) | f;
    endfunction

    // One cycle: check the results of two cycles ago, then present new operands
    task automatic step(logic [31:0] as, logic [31:0] bs, logic [63:0] ad, logic [63:0] bd);
        @(negedge clk);
        compare(1'b0, sp2, 64'(r_sp), ov_sp, un_sp);
        compare(1'b1, dp2, r_dp, ov_dp, un_dp);
        sp2  = sp1;
        dp2  = dp1;
        a_sp = as;
        b_sp = bs;
        a_dp = ad;
        b_dp = bd;
        sp1  = model(1'b0, 64'(as), 64'(bs));
        dp1  = model(1'b1, ad, bd);
    endtask

    initial begin
        exp_t z;
        z.r = '0; z.ov = 1'b0; z.un = 1'b0; z.tag = "R1 reset";

        // R1: reset clears outputs even with live operands
        a_sp = 32'h3FC00000; b_sp = 32'h7F000000;
        a_dp = 64'h3FF8000000000000; b_dp = 64'h7FE0000000000000;
        repeat (3) @(negedge clk);
        compare(1'b0, z, 64'(r_sp), ov_sp, un_sp);
        compare(1'b1, z, r_dp, ov_dp, un_dp);
        rst_n = 1'b1;
        sp2 = z;
        dp2 = z;
        sp1 = model(1'b0, 64'(a_sp), 64'(b_sp));
        dp1 = model(1'b1, a_dp, b_dp);

        // R4 R5: plain products, with and without normalization shift
        step(32'h3FC00000, 32'h3FC00000, 64'h3FF8000000000000, 64'h3FF8000000000000);
        step(32'h40000000, 32'h40400000, 64'h4000000000000000, 64'h4008000000000000);
        // R3: sign combinations
        step(32'hBF800000, 32'h3F800000, 64'hBFF0000000000000, 64'h3FF0000000000000);
        step(32'hBF800000, 32'hC0400000, 64'hBFF0000000000000, 64'hC008000000000000);
        // R5: truncation of all-ones fractions
        step(32'h3FFFFFFF, 32'h3FFFFFFF, 64'h3FFFFFFFFFFFFFFF, 64'h3FFFFFFFFFFFFFFF);
        // R2: zero operands, signed, nonzero fraction under zero exponent
        step(32'h00000000, 32'h40400000, 64'h0000000000000000, 64'h4008000000000000);
        step(32'h80000000, 32'h40400000, 64'h8000000000000000, 64'h4008000000000000);
        step(32'h00012345, 32'hC0400000, 64'h0000000000012345, 64'hC008000000000000);
        // R2 R8: zero wins over an exponent pair that would overflow
        step(mk_sp(0, 0, 0), mk_sp(1, 254, 0), mk_dp(0, 0, 0), mk_dp(1, 2046, 0));
        // R5 R6: exponent at top of range, product below 2 stays normal
        step(mk_sp(0, 254, 0), mk_sp(0, 127, 'h400000),
             mk_dp(0, 2046, 0), mk_dp(0, 1023, 64'h8000000000000));
        // R6: same exponents, normalization pushes into overflow
        step(mk_sp(1, 254, 'h400000), mk_sp(0, 127, 'h400000),
             mk_dp(1, 2046, 64'h8000000000000), mk_dp(0, 1023, 64'h8000000000000));
        step(mk_sp(0, 254, 0), mk_sp(0, 254, 0), mk_dp(0, 2046, 0), mk_dp(0, 2046, 0));
        // R7: exponent lands on zero, product below 2 underflows
        step(mk_sp(1, 1, 0), mk_sp(0, 126, 0), mk_dp(1, 1, 0), mk_dp(0, 1022, 0));
        // R5: same exponents, normalization rescues to exponent 1
        step(mk_sp(0, 1, 'h400000), mk_sp(0, 126, 'h400000),
             mk_dp(0, 1, 64'h8000000000000), mk_dp(0, 1022, 64'h8000000000000));
        step(mk_sp(0, 1, 0), mk_sp(1, 1, 0), mk_dp(0, 1, 0), mk_dp(1, 1, 0));

        // Mixed random traffic concentrated near both range edges
        for (int i = 0; i < 4000; i++) begin
            step(32'(rand_op(1'b0)), 32'(rand_op(1'b0)), rand_op(1'b1), rand_op(1'b1));
        end

        step('0, '0, '0, '0);
        step('0, '0, '0, '0);
        step('0, '0, '0, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(4ns * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: got run still active, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule